// File: doc/BRIEF.md
# Block Lock Protection Manager

This block guards the modifying operations of a sixteen-block non-volatile array. It keeps one protection bit per block and one master freeze bit. For every request (erase, word program, protect a block, set the freeze bit, unprotect all) it returns a registered verdict. That verdict is either grant or refuse, together with the status error bits to raise when the request is refused. The decision depends on the request type, the target block and the level of the reset pin. The pin has three levels: low, normal, or a high-voltage override.

The override level lets erase and program reach protected blocks until the freeze bit is set. After that, protected blocks stay untouchable for good, and the protection map itself can no longer be changed. A separate lookup port returns the protection state as identifier-space read data. The protection bits model non-volatile cells. Only the synchronous power-on `rst` clears them. The reset pin going low never clears them.

Top module: `lock_guard`

## Requirements
- R1: After `rst`, all sixteen protection bits and the freeze bit are 0, `resp_valid` is 0, and the identifier data reads 0.
- R2: A request presented with `req_valid` high gets its verdict on `resp_valid`/`resp_allow`/`resp_err` exactly one clock later. Any change to the protection state is visible to the next request.
- R3: Erase (`req_op`=0) or program (`req_op`=1) to an unprotected block at normal (1) or override (2) pin level is granted with `resp_err`=0.
- R4: Erase or program to a protected block is granted only at override level while the freeze bit is 0. Otherwise it is refused with `resp_err` bits 1 and 5 (erase, 0x22) or bits 1 and 4 (program, 0x12).
- R5: Protect-block (`req_op`=2) at normal or override level sets that block's bit when the freeze bit is 0. With the freeze bit set it is refused with 0x12 and no bit changes.
- R6: Set-freeze (`req_op`=3) is granted only at override level. At normal level it is refused with 0x12. Once set, the freeze bit is never cleared, not even by the reset pin going low.
- R7: Unprotect-all (`req_op`=4) clears all sixteen protection bits in one operation when the freeze bit is 0. With the freeze bit set it is refused with 0x12 and all bits are kept.
- R8: With the pin at low level (0), or at the unused code 3, every request is refused with `resp_err`=0 and no state changes. Opcodes 5 to 7 are refused the same way.
- R9: The identifier lookup returns, one clock after `id_blk`/`id_off` are applied, the block's protection bit on data bit 0 at offset 2. It returns the freeze bit on data bit 0 at offset 3 of block 0. Every other offset, and all upper data bits, read 0.
- R10: Protection state written before the reset pin goes low is still in effect, and still readable, after the pin returns to normal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| req_valid | input | 1 | Request strobe |
| req_op | input | 3 | 0 erase, 1 program, 2 protect block, 3 set freeze, 4 unprotect all |
| req_blk | input | 4 | Target block index |
| pin_lvl | input | 2 | Reset pin level: 0 low, 1 normal, 2 override |
| resp_valid | output | 1 | Verdict strobe, one cycle after the request |
| resp_allow | output | 1 | 1 = granted |
| resp_err | output | 8 | Status error bits to raise on refusal |
| id_blk | input | 4 | Identifier lookup block |
| id_off | input | 2 | Identifier lookup offset within the block |
| id_data | output | 16 | Identifier read data |

## Verification
The bound checker watches the following on every cycle:
- The freeze bit never falls.
- The protection map holds still while the freeze bit is set.
- A low pin never yields a grant.
- A grant never carries error bits.
- An unprotected block at normal level is always granted.
- Every request gets exactly one verdict a cycle later.

The bench's scenarios, compared against a behavioural model, show the things no per-cycle property covers:
- The exact error codes for each refusal.
- The bulk clear.
- The ordering effect of setting the freeze bit between two otherwise identical requests.
- Survival of the map across a low pin.
- The identifier offsets.

// File: rtl/lockmgr_pkg.sv
package lockmgr_pkg;
  localparam int SRW       = 8;
  localparam int SR_LOCK   = 1;
  localparam int SR_PROG   = 4;
  localparam int SR_ERASE  = 5;

  typedef enum logic [2:0] {
    OP_ERASE   = 3'd0,
    OP_PROG    = 3'd1,
    OP_PROTECT = 3'd2,
    OP_FREEZE  = 3'd3,
    OP_CLRALL  = 3'd4
  } op_e;

  typedef enum logic [1:0] {
    PIN_LOW  = 2'd0,
    PIN_NORM = 2'd1,
    PIN_OVR  = 2'd2
  } pin_e;

  typedef struct packed {
    logic           allow;
    logic [SRW-1:0] err;
    logic           set_blk;
    logic           set_frz;
    logic           clr_all;
  } verdict_t;
endpackage

// File: rtl/lock_policy.sv
module lock_policy
  import lockmgr_pkg::*;
(
  input  logic [2:0] op,
  input  logic [1:0] pin,
  input  logic       blk_prot,
  input  logic       frozen,
  output verdict_t   v
);
  logic pin_ok, pin_ovr;
  logic [SRW-1:0] e_lock, e_prog, e_erase;

  always_comb begin
    pin_ok  = (pin == PIN_NORM) || (pin == PIN_OVR);
    pin_ovr = (pin == PIN_OVR);
    e_lock  = '0;
    e_lock[SR_LOCK] = 1'b1;
    e_prog  = e_lock;
    e_prog[SR_PROG] = 1'b1;
    e_erase = e_lock;
    e_erase[SR_ERASE] = 1'b1;

    v = '0;
    if (pin_ok) begin
      case (op)
        OP_ERASE, OP_PROG: begin
          if (!blk_prot || (pin_ovr && !frozen)) v.allow = 1'b1;
          else v.err = (op == OP_ERASE) ? e_erase : e_prog;
        end
        OP_PROTECT: begin
          if (!frozen) begin
            v.allow   = 1'b1;
            v.set_blk = 1'b1;
          end else v.err = e_prog;
        end
        OP_FREEZE: begin
          if (pin_ovr) begin
            v.allow   = 1'b1;
            v.set_frz = 1'b1;
          end else v.err = e_prog;
        end
        OP_CLRALL: begin
          if (!frozen) begin
            v.allow   = 1'b1;
            v.clr_all = 1'b1;
          end else v.err = e_prog;
        end
        default: v = '0;
      endcase
    end
  end
endmodule

// File: rtl/lock_store.sv
module lock_store
  import lockmgr_pkg::*;
#(
  parameter int NBLK = 16,
  localparam int BW  = $clog2(NBLK)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            upd,
  input  verdict_t        v,
  input  logic [BW-1:0]   blk,
  output logic [NBLK-1:0] prot_q,
  output logic            frz_q
);
  for (genvar g = 0; g < NBLK; g++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) prot_q[g] <= 1'b0;
      else if (upd && v.clr_all) prot_q[g] <= 1'b0;
      else if (upd && v.set_blk && (blk == BW'(g))) prot_q[g] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) frz_q <= 1'b0;
    else if (upd && v.set_frz) frz_q <= 1'b1;
  end
endmodule

// File: rtl/lock_id_read.sv
module lock_id_read #(
  parameter int NBLK = 16,
  parameter int DW   = 16,
  parameter int OFFW = 2,
  localparam int BW  = $clog2(NBLK)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [BW-1:0]   id_blk,
  input  logic [OFFW-1:0] id_off,
  input  logic [NBLK-1:0] prot_q,
  input  logic            frz_q,
  output logic [DW-1:0]   id_data
);
  localparam logic [OFFW-1:0] OFF_BLK = OFFW'(2);
  localparam logic [OFFW-1:0] OFF_FRZ = OFFW'(3);

  logic bit0;
  always_comb begin
    bit0 = 1'b0;
    if (id_off == OFF_BLK) bit0 = prot_q[id_blk];
    else if (id_off == OFF_FRZ && id_blk == '0) bit0 = frz_q;
  end

  always_ff @(posedge clk) begin
    if (rst) id_data <= '0;
    else     id_data <= {{(DW-1){1'b0}}, bit0};
  end
endmodule

// File: rtl/lock_guard.sv
module lock_guard
  import lockmgr_pkg::*;
#(
  parameter int NBLK = 16,
  parameter int DW   = 16,
  parameter int OFFW = 2,
  localparam int BW  = $clog2(NBLK)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  input  logic [2:0]      req_op,
  input  logic [BW-1:0]   req_blk,
  input  logic [1:0]      pin_lvl,
  output logic            resp_valid,
  output logic            resp_allow,
  output logic [SRW-1:0]  resp_err,
  input  logic [BW-1:0]   id_blk,
  input  logic [OFFW-1:0] id_off,
  output logic [DW-1:0]   id_data
);
  logic [NBLK-1:0] prot_q;
  logic            frz_q;
  verdict_t        v;

  lock_policy u_policy (
    .op(req_op), .pin(pin_lvl), .blk_prot(prot_q[req_blk]),
    .frozen(frz_q), .v(v)
  );

  lock_store #(.NBLK(NBLK)) u_store (
    .clk(clk), .rst(rst), .upd(req_valid), .v(v), .blk(req_blk),
    .prot_q(prot_q), .frz_q(frz_q)
  );

  lock_id_read #(.NBLK(NBLK), .DW(DW), .OFFW(OFFW)) u_id (
    .clk(clk), .rst(rst), .id_blk(id_blk), .id_off(id_off),
    .prot_q(prot_q), .frz_q(frz_q), .id_data(id_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      resp_valid <= 1'b0;
      resp_allow <= 1'b0;
      resp_err   <= '0;
    end else begin
      resp_valid <= req_valid;
      resp_allow <= req_valid && v.allow;
      resp_err   <= req_valid ? v.err : '0;
    end
  end
endmodule

// File: rtl/lock_guard_chk.sv
module lock_guard_chk #(
  parameter int NBLK = 16,
  localparam int BW  = $clog2(NBLK)
) (
  input logic            clk,
  input logic            rst,
  input logic            req_valid,
  input logic [2:0]      req_op,
  input logic [BW-1:0]   req_blk,
  input logic [1:0]      pin_lvl,
  input logic            resp_valid,
  input logic            resp_allow,
  input logic [7:0]      resp_err,
  input logic [NBLK-1:0] prot_q,
  input logic            frz_q
);
  // R6
  frz_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    frz_q |=> frz_q);

  // R5
  frz_map_hold_chk: assert property (@(posedge clk) disable iff (rst)
    frz_q |=> $stable(prot_q));

  // R8
  low_pin_refuse_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && pin_lvl == 2'd0) |=> (resp_valid && !resp_allow && resp_err == 8'd0));

  // R3
  grant_clean_chk: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && resp_allow) |-> (resp_err == 8'd0));

  // R3
  open_block_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_op <= 3'd1 && pin_lvl == 2'd1 && !prot_q[req_blk]) |=> resp_allow);

  // R2
  one_verdict_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> resp_valid);

  // R2
  no_spurious_chk: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !resp_valid);
endmodule

bind lock_guard lock_guard_chk #(.NBLK(NBLK)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
  .req_blk(req_blk), .pin_lvl(pin_lvl), .resp_valid(resp_valid),
  .resp_allow(resp_allow), .resp_err(resp_err), .prot_q(prot_q), .frz_q(frz_q)
);

// File: tb/test_lock_guard.sv
module test_lock_guard;
  logic clk = 0;
  logic rst = 1;
  logic req_valid = 0;
  logic [2:0] req_op = 0;
  logic [3:0] req_blk = 0;
  logic [1:0] pin_lvl = 1;
  logic [3:0] id_blk = 0;
  logic [1:0] id_off = 0;
  logic resp_valid, resp_allow;
  logic [7:0] resp_err;
  logic [15:0] id_data;

  int checks = 0;
  int errors = 0;
  bit [15:0] m_prot = 0;
  bit m_frz = 0;

  always #2 clk = ~clk;

  lock_guard i_lock_guard (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_blk(req_blk), .pin_lvl(pin_lvl), .resp_valid(resp_valid),
    .resp_allow(resp_allow), .resp_err(resp_err), .id_blk(id_blk),
    .id_off(id_off), .id_data(id_data)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  // behavioural reference of the verdict
  task automatic model(int op, int blk, int pin, output bit a, output bit [7:0] e);
    bit ok = (pin == 1) || (pin == 2);
    bit ovr = (pin == 2);
    a = 0; e = 0;
    if (!ok || op > 4) return;
    if (op <= 1) begin
      if (!m_prot[blk] || (ovr && !m_frz)) a = 1;
      else e = (op == 0) ? 8'h22 : 8'h12;
    end else if (op == 2) begin
      if (!m_frz) begin a = 1; m_prot[blk] = 1; end else e = 8'h12;
    end else if (op == 3) begin
      if (ovr) begin a = 1; m_frz = 1; end else e = 8'h12;
    end else begin
      if (!m_frz) begin a = 1; m_prot = 0; end else e = 8'h12;
    end
  endtask

  task automatic issue(string req, int op, int blk, int pin);
    bit a; bit [7:0] e;
    model(op, blk, pin, a, e);
    req_valid = 1; req_op = 3'(op); req_blk = 4'(blk); pin_lvl = 2'(pin);
    @(negedge clk);
    req_valid = 0;
    chk({req, " valid"}, 32'(resp_valid), 32'd1);
    chk({req, " allow"}, 32'(resp_allow), 32'(a));
    chk({req, " err"}, 32'(resp_err), 32'(e));
    @(negedge clk);
    chk({req, " idle"}, 32'(resp_valid), 32'd0);
  endtask

  task automatic idread(string req, int blk, int off);
    bit [15:0] exp = 0;
    if (off == 2) exp[0] = m_prot[blk];
    else if (off == 3 && blk == 0) exp[0] = m_frz;
    id_blk = 4'(blk); id_off = 2'(off);
    @(negedge clk);
    chk(req, 32'(id_data), 32'(exp));
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1 resp_valid", 32'(resp_valid), 0);
    for (int b = 0; b < 16; b++) idread("R1 id prot", b, 2);
    idread("R1 id frz", 0, 3);
    // R3 open blocks
    issue("R3 erase open", 0, 3, 1);
    issue("R3 prog open ovr", 1, 9, 2);
    // R5 protect, R2 visible next request
    issue("R5 protect 3", 2, 3, 1);
    issue("R2 R4 prog prot", 1, 3, 1);
    issue("R4 erase prot", 0, 3, 1);
    issue("R4 erase prot ovr", 0, 3, 2);
    issue("R4 prog prot ovr", 1, 3, 2);
    // R8 low pin and bad codes
    issue("R8 low protect", 2, 4, 0);
    issue("R8 pin code3", 0, 3, 3);
    issue("R8 bad op", 6, 3, 1);
    idread("R8 R9 blk4 untouched", 4, 2);
    idread("R9 blk3", 3, 2);
    idread("R9 off0", 3, 0);
    idread("R9 off3 blk1", 1, 3);
    // R7 clear all
    issue("R5 protect 7", 2, 7, 2);
    issue("R5 protect 15", 2, 15, 1);
    issue("R7 clear", 4, 0, 1);
    for (int b = 0; b < 16; b++) idread("R7 cleared", b, 2);
    issue("R5 protect 3 again", 2, 3, 1);
    issue("R5 protect 0", 2, 0, 1);
    // R6 freeze needs override
    issue("R6 freeze normal", 3, 0, 1);
    idread("R6 frz still 0", 0, 3);
    issue("R6 freeze ovr", 3, 0, 2);
    idread("R9 frz bit", 0, 3);
    // frozen behaviour
    issue("R4 frozen erase ovr", 0, 3, 2);
    issue("R4 frozen prog ovr", 1, 0, 2);
    issue("R3 frozen open blk", 1, 5, 1);
    issue("R5 frozen protect", 2, 5, 2);
    issue("R7 frozen clear", 4, 0, 2);
    idread("R7 blk3 kept", 3, 2);
    idread("R5 blk5 still 0", 5, 2);
    // R10 pin low period
    pin_lvl = 0;
    repeat (5) @(negedge clk);
    pin_lvl = 1;
    @(negedge clk);
    idread("R10 blk0 kept", 0, 2);
    idread("R10 frz kept", 0, 3);
    issue("R10 R6 erase after low", 0, 0, 2);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule